// File: doc/BRIEF.md
# Boot Descriptor Header Validator

This block checks a firmware communication descriptor that a loader streams in one byte per cycle. The first 16 bytes form a header: a magic word, a reference CRC, a body length, a version byte and five padding bytes. The block checks the header fields as they arrive. It counts the body bytes against the declared length and runs a reflected CRC-32 over the body only. When the frame ends it reports pass or fail with a cause code. On a pass it also presents the 64-bit next-image load address taken from its fixed place near the end of the body.

Bytes come in on a valid/ready stream. A byte moves on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low while reset is asserted and rises on the first clock after reset is released. It then stays high, so the source never sees back-pressure. The source may drop `in_valid` for any number of cycles between bytes. `in_start` marks header byte 0 and `in_last` marks the final byte. The results are held from the cycle after the last byte until the next start byte is accepted.

Top module: `boot_desc_checker`

## Requirements
- R1: `in_ready` is 0 during reset and 1 from the first clock after reset release. A byte is taken only when `in_valid` and `in_ready` are both 1, and gaps in `in_valid` between bytes do not change the result.
- R2: Header bytes 0..3, little-endian, must equal 0x4843444D, otherwise cause 1 (bad magic).
- R3: Header byte 10 must equal 1, otherwise cause 2 (bad version).
- R4: Header bytes 8..9, little-endian, give the body length N. If `in_last` arrives on any byte other than byte 15+N, the cause is 3 (length mismatch). This covers frames that end inside the header, frames with a short body and frames with a long body.
- R5: Header bytes 4..7, little-endian, hold the reflected CRC-32 of the body bytes only (polynomial 0xEDB88320, init 0xFFFFFFFF, final XOR 0xFFFFFFFF). A mismatch gives cause 4. Header bytes, including the padding bytes 11..15, do not enter the CRC. An empty body has CRC 0.
- R6: The cause codes are 0 none, 1 magic, 2 version, 3 length, 4 CRC. When several faults are present, the cause of the first one found in stream order is reported. `ok` is 1 exactly when `done` is 1 and the cause is 0.
- R7: `done`, `ok` and `cause` update on the clock edge that accepts the last byte, so they are visible in the following cycle. They hold until a new start byte is accepted, which clears them on that edge.
- R8: `img_addr` is body bytes 616..623 (frame bytes 632..639), little-endian. It reads 0 whenever `ok` is 0, and also reads 0 if the body was too short to reach those bytes.
- R9: Bytes offered with `in_start` low while no frame is open are ignored and leave the held results unchanged. A start byte in the middle of a frame abandons that frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Block accepts the offered byte |
| in_start | input | 1 | Offered byte is header byte 0 |
| in_last | input | 1 | Offered byte is the final byte of the frame |
| in_data | input | 8 | Descriptor byte |
| done | output | 1 | A frame has finished; results are valid |
| ok | output | 1 | Frame passed every check |
| cause | output | 3 | Fail cause code (0 when not done) |
| img_addr | output | 64 | Next-image load address, 0 unless ok |

## Verification
The bench aims at the length rule from both sides. A body that ends one byte early or runs one byte long must give cause 3, and an empty body must pass with a CRC of zero. A design that counted the header bytes into the length, or checked only one direction, would pass one of these frames. The bench changes a padding byte with the CRC left as it was, to catch a CRC that wrongly covers the header. It also builds frames with two faults to pin down the first-found priority. Bytes sent while no frame is open, a start in the middle of a frame and gaps in `in_valid` are all used to expose a counter that advances on the wrong condition or fails to restart.

// File: rtl/bdc_pkg.sv
`timescale 1ns/1ps
package bdc_pkg;
  localparam logic [31:0] DESC_MAGIC = 32'h4843444D;
  localparam logic [7:0]  DESC_VER   = 8'd1;
  localparam int          HDR_BYTES  = 16;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_MAGIC = 3'd1,
    FC_VER   = 3'd2,
    FC_LEN   = 3'd3,
    FC_CRC   = 3'd4
  } fail_e;

  // One byte through the reflected CRC-32, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/bdc_hdr.sv
`timescale 1ns/1ps
module bdc_hdr #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             magic_hit,
  output logic [31:0]      crc_ref,
  output logic [15:0]      body_len
);
  import bdc_pkg::*;

  logic [23:0] mag_q;
  logic [31:0] crc_q;
  logic [15:0] len_q;

  // The magic word is complete on the byte at index 3.
  assign magic_hit = ({data, mag_q} == DESC_MAGIC);
  assign crc_ref   = crc_q;
  assign body_len  = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_q <= '0;
      crc_q <= '0;
      len_q <= '0;
    end else if (take && idx < CNT_W'(HDR_BYTES)) begin
      case (idx[3:0])
        4'd0: mag_q[7:0]   <= data;
        4'd1: mag_q[15:8]  <= data;
        4'd2: mag_q[23:16] <= data;
        4'd4: crc_q[7:0]   <= data;
        4'd5: crc_q[15:8]  <= data;
        4'd6: crc_q[23:16] <= data;
        4'd7: crc_q[31:24] <= data;
        4'd8: len_q[7:0]   <= data;
        4'd9: len_q[15:8]  <= data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bdc_crc.sv
`timescale 1ns/1ps
module bdc_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof,
  input  logic        take_body,
  input  logic [7:0]  data,
  output logic [31:0] crc_res
);
  import bdc_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] crc_upd;

  assign crc_upd = crc32_step(crc_q, data);
  // Final value including the byte taken this cycle.
  assign crc_res = (take_body ? crc_upd : crc_q) ^ 32'hFFFFFFFF;

  always_ff @(posedge clk) begin
    if (!rst_n)         crc_q <= CRC_INIT;
    else if (sof)       crc_q <= CRC_INIT;
    else if (take_body) crc_q <= crc_upd;
  end
endmodule

// File: rtl/bdc_addr.sv
`timescale 1ns/1ps
module bdc_addr #(
  parameter int CNT_W    = 18,
  parameter int ADDR_OFS = 616
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             take,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [63:0]      addr
);
  import bdc_pkg::*;

  localparam int FIRST = HDR_BYTES + ADDR_OFS;

  for (genvar k = 0; k < 8; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  lane_q <= '0;
      else if (sof)                                lane_q <= '0;
      else if (take && idx == CNT_W'(FIRST + k))   lane_q <= data;
    end
    assign addr[8*k +: 8] = lane_q;
  end
endmodule

// File: rtl/boot_desc_checker.sv
`timescale 1ns/1ps
module boot_desc_checker #(
  parameter int REGMAP_WORDS = 58,
  parameter int VSTR_BYTES   = 128,
  parameter int VSTR_NUM     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_start,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  output logic        done,
  output logic        ok,
  output logic [2:0]  cause,
  output logic [63:0] img_addr
);
  import bdc_pkg::*;

  localparam int LEN_W    = 16;
  localparam int ADDR_OFS = REGMAP_WORDS * 4 + VSTR_NUM * VSTR_BYTES;
  localparam int CNT_W    = $clog2(HDR_BYTES + (1 << LEN_W)) + 1;

  logic             ready_q, busy_q, done_q;
  fail_e            err_q, err_prev, err_nx;
  logic [CNT_W-1:0] cnt_q, idx, end_idx;
  logic             sof, take, take_body;
  logic             magic_hit;
  logic [31:0]      crc_ref, crc_res;
  logic [15:0]      body_len;
  logic [63:0]      addr_raw;
  logic             e_magic, e_ver, e_len, e_crc;

  assign in_ready  = ready_q;
  assign sof       = in_valid & ready_q & in_start;
  assign take      = in_valid & ready_q & (in_start | busy_q);
  assign idx       = in_start ? '0 : cnt_q;
  assign take_body = take && (idx >= CNT_W'(HDR_BYTES));
  assign end_idx   = CNT_W'(HDR_BYTES - 1) + CNT_W'(body_len);

  bdc_hdr #(.CNT_W(CNT_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data),
    .magic_hit(magic_hit), .crc_ref(crc_ref), .body_len(body_len)
  );

  bdc_crc u_crc (
    .clk(clk), .rst_n(rst_n), .sof(sof), .take_body(take_body),
    .data(in_data), .crc_res(crc_res)
  );

  bdc_addr #(.CNT_W(CNT_W), .ADDR_OFS(ADDR_OFS)) u_addr (
    .clk(clk), .rst_n(rst_n), .sof(sof), .take(take), .idx(idx),
    .data(in_data), .addr(addr_raw)
  );

  // Per-byte fault detection, in stream order.
  assign e_magic = (idx == CNT_W'(3)) && !magic_hit;
  assign e_ver   = (idx == CNT_W'(10)) && (in_data != DESC_VER);
  assign e_len   = (idx < CNT_W'(HDR_BYTES - 1)) ? in_last : (in_last != (idx == end_idx));
  assign e_crc   = in_last && (crc_res != crc_ref);
  assign err_prev = in_start ? FC_NONE : err_q;

  always_comb begin
    err_nx = err_prev;
    if (err_prev == FC_NONE) begin
      if (e_magic)    err_nx = FC_MAGIC;
      else if (e_ver) err_nx = FC_VER;
      else if (e_len) err_nx = FC_LEN;
      else if (e_crc) err_nx = FC_CRC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= FC_NONE;
      cnt_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (take) begin
        cnt_q  <= (idx == '1) ? idx : idx + 1'b1;
        err_q  <= err_nx;
        busy_q <= !in_last;
        done_q <= in_last;
      end
    end
  end

  assign done     = done_q;
  assign cause    = done_q ? err_q : FC_NONE;
  assign ok       = done_q && (err_q == FC_NONE);
  assign img_addr = ok ? addr_raw : 64'd0;

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
  // R6
  ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (done && cause == 3'd0));
  // R6
  fail_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (cause >= 3'd1 && cause <= 3'd4));
  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !in_last) |=> !done);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !take) |=> (done && $stable(cause) && $stable(img_addr)));
endmodule

// File: tb/sim_boot_desc_checker.sv
`timescale 1ns/1ps
module sim_boot_desc_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, done, ok;
  logic [2:0]  cause;
  logic [63:0] img_addr;

  int checks = 0, errors = 0;
  logic [7:0] fr [0:1023];
  localparam logic [63:0] ADDR_VAL = 64'h0123456789ABCDEF;

  always #2 clk = ~clk;

  boot_desc_checker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_last(in_last), .in_data(in_data),
    .done(done), .ok(ok), .cause(cause), .img_addr(img_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int blen);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < blen; i++) begin
      c ^= {24'd0, fr[16 + i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c ^ 32'hFFFFFFFF;
  endfunction

  // Body of blen bytes, header declaring decl bytes.
  task automatic build(input int blen, input int decl);
    logic [31:0] c;
    for (int i = 0; i < blen; i++) fr[16 + i] = 8'((i * 37 + 11) ^ (i >> 4));
    if (blen >= 624) for (int k = 0; k < 8; k++) fr[16 + 616 + k] = ADDR_VAL[8*k +: 8];
    c = ref_crc(blen);
    fr[0] = 8'h4D; fr[1] = 8'h44; fr[2] = 8'h43; fr[3] = 8'h48;
    for (int k = 0; k < 4; k++) fr[4 + k] = c[8*k +: 8];
    fr[8] = 8'(decl); fr[9] = 8'(decl >> 8); fr[10] = 8'd1;
    for (int k = 11; k < 16; k++) fr[k] = 8'd0;
  endtask

  task automatic send(input int n, input bit gaps, input bit with_start, input bit with_last);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); in_valid = 1'b0; in_data = 8'hA5;
        @(negedge clk);
      end else @(negedge clk);
      in_valid = 1'b1;
      in_start = with_start && (i == 0);
      in_last  = with_last && (i == n - 1);
      in_data  = fr[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_res(input string req, input bit e_ok, input int e_cause, input logic [63:0] e_addr);
    chk({req, " done"}, 64'(done), 64'd1);
    chk({req, " ok"}, 64'(ok), 64'(e_ok));
    chk({req, " cause"}, 64'(cause), 64'(e_cause));
    chk({req, " img_addr"}, img_addr, e_addr);
  endtask

  task automatic t_reset;
    chk("R1 ready in reset", 64'(in_ready), 64'd0);
    chk("R7 done at reset", 64'(done), 64'd0);
    chk("R6 cause at reset", 64'(cause), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_good;
    build(624, 624); send(640, 0, 1, 1);
    expect_res("R8 good frame", 1, 0, ADDR_VAL);
  endtask

  task automatic t_gaps;
    build(624, 624); send(640, 1, 1, 1);
    expect_res("R1 gaps in valid", 1, 0, ADDR_VAL);
  endtask

  task automatic t_magic;
    build(624, 624); fr[3] = 8'h49; send(640, 0, 1, 1);
    expect_res("R2 bad magic", 0, 1, 0);
  endtask

  task automatic t_version;
    build(624, 624); fr[10] = 8'd2; send(640, 0, 1, 1);
    expect_res("R3 bad version", 0, 2, 0);
  endtask

  task automatic t_priority;
    build(624, 624); fr[0] = 8'h00; fr[10] = 8'd7; send(640, 0, 1, 1);
    expect_res("R6 magic before version", 0, 1, 0);
    build(100, 100); fr[10] = 8'd0; fr[20] = ~fr[20]; send(115, 0, 1, 1);
    expect_res("R6 version before length", 0, 2, 0);
  endtask

  task automatic t_length;
    build(624, 624); send(639, 0, 1, 1);
    expect_res("R4 short body", 0, 3, 0);
    build(625, 624); send(641, 0, 1, 1);
    expect_res("R4 long body", 0, 3, 0);
    build(624, 624); send(9, 0, 1, 1);
    expect_res("R4 last inside header", 0, 3, 0);
  endtask

  task automatic t_crc;
    build(624, 624); fr[300] = fr[300] ^ 8'h10; send(640, 0, 1, 1);
    expect_res("R5 body corrupted", 0, 4, 0);
    build(624, 624); fr[13] = 8'hFF; send(640, 0, 1, 1);
    expect_res("R5 padding outside crc", 1, 0, ADDR_VAL);
    build(0, 0); send(16, 0, 1, 1);
    expect_res("R5 empty body", 1, 0, 0);
    build(8, 8); send(24, 0, 1, 1);
    expect_res("R8 short body no address", 1, 0, 0);
  endtask

  task automatic t_ignore_restart;
    build(624, 624); fr[1] = 8'h00; send(640, 0, 1, 1);
    expect_res("R9 setup", 0, 1, 0);
    build(624, 624); send(40, 0, 0, 1);
    expect_res("R9 idle bytes ignored", 0, 1, 0);
    send(30, 0, 1, 0);
    chk("R7 start clears done", 64'(done), 64'd0);
    chk("R7 start clears cause", 64'(cause), 64'd0);
    send(640, 0, 1, 1);
    expect_res("R9 restart mid-frame", 1, 0, ADDR_VAL);
  endtask

  initial begin
    t_reset();
    t_good();
    t_gaps();
    t_magic();
    t_version();
    t_priority();
    t_length();
    t_crc();
    t_ignore_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule